// File: doc/BRIEF.md
# Partition-Gated OTP Read Controller

This block sits between a host register bus and a one-time-programmable word array. Software reads a word in three steps. It writes a byte offset into the offset register. It then writes the read command into the control/status register. Finally it polls the DONE flag and takes the word from the read-data register. The controller turns the byte offset into a word address, fetches the word over a request/grant, response-valid memory port, and reports the result.

The offset is decoded against a fixed partition map. Once the lifecycle input reports that provisioning is complete, only the hardware-configuration and lifecycle partitions may be read. A read that targets a secret partition then completes at once with ERR set, returns zero, and never reaches the array. Misaligned offsets and offsets that fall outside the map are rejected in the same way. Before provisioning, every partition in the map is readable.

Top module: `otp_rd_ctrl`

## Requirements
- R1: The control/status register is at 0x200, the offset register at 0x204 and the read-data register at 0x208. The offset register reads back the full 32-bit value last written. Any other address reads as zero.
- R2: A write to 0x200 whose low byte equals 0x01 starts a read when the controller is idle. Any other low byte is ignored: status, read data and the memory port all stay unchanged.
- R3: A permitted read ends with status bit 0 (DONE) at 1 and bit 1 (ERR) at 0. The read-data register then holds the array word at word address offset/4.
- R4: The partition map uses byte offsets. 0x00–0x3F is hardware configuration (open). 0x40–0x7F and 0x80–0xBF are secret. 0xC0–0xDF is lifecycle (open). With the provisioned input at 1, a read of a secret partition ends with DONE=1, ERR=1 and read data zero, and no memory request is issued.
- R5: With the provisioned input at 0, every partition, including the secret ones, is readable as in R3.
- R6: An offset whose two low bits are not zero ends with DONE=1, ERR=1 and read data zero, without a memory request.
- R7: An offset of 0xE0 or above ends with DONE=1, ERR=1 and read data zero, without a memory request. The word address driven to the array is always below 56.
- R8: A read command written while a read is in flight is ignored and the first read completes with its own data. Accepting a command clears DONE.
- R9: After reset, status, offset and read data all read as zero and no memory request is pending.
- R10: Once raised, the memory request stays asserted with a stable word address until the grant is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prov_done_i | input | 1 | Lifecycle says provisioning is complete |
| reg_we_i | input | 1 | Host register write strobe |
| reg_addr_i | input | 12 | Host register byte address |
| reg_wdata_i | input | 32 | Host write data |
| reg_rdata_o | output | 32 | Host read data (combinational on reg_addr_i) |
| otp_req_o | output | 1 | Array read request |
| otp_addr_o | output | 6 | Array word address |
| otp_gnt_i | input | 1 | Array accepts the request |
| otp_rvalid_i | input | 1 | Array returns a word |
| otp_rdata_i | input | 32 | Array word |

## Verification
Suppose the partition gate latched the wrong lifecycle or the wrong offset. The very next poll would show the wrong ERR value. The memory model's request count would also change where it should not, so a leak of a secret read is visible within one command. A sequencer stuck busy or wrongly idle shows up as a missing DONE within the poll limit, or as a second request and foreign data when commands overlap. Randomized grant and response delays move each completion to a different cycle, so the bench never depends on one fixed latency.

// File: rtl/otp_rd_pkg.sv
package otp_rd_pkg;

  localparam int unsigned NUM_PART = 4;
  localparam int unsigned PW       = 16;
  localparam int unsigned DW       = 32;
  localparam int unsigned REG_AW   = 12;

  typedef struct packed {
    logic [PW-1:0] base;   // first word
    logic [PW-1:0] words;  // size in words
    logic          secret;
  } part_t;

  // index 0 = hw config, 1..2 = secrets, 3 = lifecycle
  localparam part_t [NUM_PART-1:0] PART_MAP = '{
    '{base: 16'd48, words: 16'd8,  secret: 1'b0},
    '{base: 16'd32, words: 16'd16, secret: 1'b1},
    '{base: 16'd16, words: 16'd16, secret: 1'b1},
    '{base: 16'd0,  words: 16'd16, secret: 1'b0}
  };

  function automatic int unsigned map_end();
    int unsigned e = 0;
    for (int i = 0; i < NUM_PART; i++) begin
      if (int'(PART_MAP[i].base) + int'(PART_MAP[i].words) > e)
        e = int'(PART_MAP[i].base) + int'(PART_MAP[i].words);
    end
    return e;
  endfunction

  localparam int unsigned TOTAL_WORDS = map_end();
  localparam int unsigned OTP_AW      = $clog2(TOTAL_WORDS);

  localparam logic [REG_AW-1:0] REG_CTRL  = 12'h200;
  localparam logic [REG_AW-1:0] REG_OFFS  = 12'h204;
  localparam logic [REG_AW-1:0] REG_RDATA = 12'h208;

  localparam logic [7:0] CMD_READ = 8'h01;
  localparam int unsigned STS_DONE = 0;
  localparam int unsigned STS_ERR  = 1;

  typedef enum logic [1:0] {
    RD_IDLE,
    RD_REQ,
    RD_WAIT
  } rd_state_e;

endpackage

// File: rtl/otp_part_decode.sv
module otp_part_decode
  import otp_rd_pkg::*;
(
  input  logic [DW-1:0]     offset_i,
  input  logic              prov_i,
  output logic              ok_o,
  output logic [OTP_AW-1:0] word_o
);

  logic [DW-3:0]       word;
  logic [NUM_PART-1:0] hit;
  logic [NUM_PART-1:0] open_part;

  assign word = offset_i[DW-1:2];

  for (genvar i = 0; i < NUM_PART; i++) begin : g_part
    logic [DW-3:0] lo, hi;
    assign lo = (DW-2)'(PART_MAP[i].base);
    assign hi = lo + (DW-2)'(PART_MAP[i].words);
    assign hit[i] = (word >= lo) && (word < hi);
    assign open_part[i] = hit[i] && !(PART_MAP[i].secret && prov_i);
  end

  assign ok_o   = (offset_i[1:0] == 2'b00) && (|open_part);
  assign word_o = word[OTP_AW-1:0];

endmodule

// File: rtl/otp_rd_seq.sv
module otp_rd_seq
  import otp_rd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_i,
  input  logic              ok_i,
  input  logic [OTP_AW-1:0] word_i,
  output logic              otp_req_o,
  output logic [OTP_AW-1:0] otp_addr_o,
  input  logic              otp_gnt_i,
  input  logic              otp_rvalid_i,
  input  logic [DW-1:0]     otp_rdata_i,
  output logic              accept_o,
  output logic              cpl_o,
  output logic              cpl_err_o,
  output logic [DW-1:0]     cpl_data_o
);

  rd_state_e         state_q, state_d;
  logic [OTP_AW-1:0] addr_q;

  assign accept_o = cmd_i && (state_q == RD_IDLE);

  always_comb begin
    state_d   = state_q;
    cpl_o     = 1'b0;
    cpl_err_o = 1'b0;
    unique case (state_q)
      RD_IDLE: if (accept_o) begin
        if (ok_i) state_d = RD_REQ;
        else begin
          cpl_o     = 1'b1;  // rejected: finish without touching the array
          cpl_err_o = 1'b1;
        end
      end
      RD_REQ:  if (otp_gnt_i) state_d = RD_WAIT;
      RD_WAIT: if (otp_rvalid_i) begin
        cpl_o   = 1'b1;
        state_d = RD_IDLE;
      end
      default: state_d = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RD_IDLE;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept_o && ok_i) addr_q <= word_i;
    end
  end

  assign otp_req_o  = (state_q == RD_REQ);
  assign otp_addr_o = addr_q;
  assign cpl_data_o = otp_rdata_i;

  a_r10_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (otp_req_o && !otp_gnt_i) |=> (otp_req_o && $stable(otp_addr_o)));

endmodule

// File: rtl/otp_rd_regs.sv
module otp_rd_regs
  import otp_rd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [DW-1:0]     offset_o,
  output logic              cmd_o,
  input  logic              accept_i,
  input  logic              cpl_i,
  input  logic              cpl_err_i,
  input  logic [DW-1:0]     cpl_data_i
);

  logic [DW-1:0] offset_q, rdata_q;
  logic          done_q, err_q;
  logic [DW-1:0] status;

  assign cmd_o = we_i && (addr_i == REG_CTRL) && (wdata_i[7:0] == CMD_READ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      offset_q <= '0;
      rdata_q  <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (we_i && (addr_i == REG_OFFS)) offset_q <= wdata_i;
      // completion wins over accept (rejects do both in one cycle)
      if (cpl_i) begin
        done_q  <= 1'b1;
        err_q   <= cpl_err_i;
        rdata_q <= cpl_err_i ? '0 : cpl_data_i;
      end else if (accept_i) begin
        done_q <= 1'b0;
        err_q  <= 1'b0;
      end
    end
  end

  always_comb begin
    status           = '0;
    status[STS_DONE] = done_q;
    status[STS_ERR]  = err_q;
    unique case (addr_i)
      REG_CTRL:  rdata_o = status;
      REG_OFFS:  rdata_o = offset_q;
      REG_RDATA: rdata_o = rdata_q;
      default:   rdata_o = '0;
    endcase
  end

  assign offset_o = offset_q;

  a_r8_done_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && !cpl_i) |=> !done_q);

  a_r4_err_zero_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpl_i && cpl_err_i) |=> (err_q && done_q && rdata_q == '0));

endmodule

// File: rtl/otp_rd_ctrl.sv
module otp_rd_ctrl
  import otp_rd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prov_done_i,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              otp_req_o,
  output logic [OTP_AW-1:0] otp_addr_o,
  input  logic              otp_gnt_i,
  input  logic              otp_rvalid_i,
  input  logic [DW-1:0]     otp_rdata_i
);

  logic [DW-1:0]     offset;
  logic              cmd, dec_ok, accept, cpl, cpl_err;
  logic [OTP_AW-1:0] dec_word;
  logic [DW-1:0]     cpl_data;

  otp_rd_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .offset_o   (offset),
    .cmd_o      (cmd),
    .accept_i   (accept),
    .cpl_i      (cpl),
    .cpl_err_i  (cpl_err),
    .cpl_data_i (cpl_data)
  );

  otp_part_decode u_dec (
    .offset_i (offset),
    .prov_i   (prov_done_i),
    .ok_o     (dec_ok),
    .word_o   (dec_word)
  );

  otp_rd_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_i        (cmd),
    .ok_i         (dec_ok),
    .word_i       (dec_word),
    .otp_req_o    (otp_req_o),
    .otp_addr_o   (otp_addr_o),
    .otp_gnt_i    (otp_gnt_i),
    .otp_rvalid_i (otp_rvalid_i),
    .otp_rdata_i  (otp_rdata_i),
    .accept_o     (accept),
    .cpl_o        (cpl),
    .cpl_err_o    (cpl_err),
    .cpl_data_o   (cpl_data)
  );

  a_r4_blocked_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !dec_ok) |=> !otp_req_o);

  a_r7_addr_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    otp_req_o |-> (int'(otp_addr_o) < TOTAL_WORDS));

endmodule

// File: tb/otp_rd_ctrl_bench.sv
`timescale 1ns/1ps
module otp_rd_ctrl_bench;
  import otp_rd_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              prov;
  logic              we;
  logic [REG_AW-1:0] addr;
  logic [DW-1:0]     wdata;
  logic [DW-1:0]     rdata;
  logic              otp_req;
  logic [OTP_AW-1:0] otp_addr;
  logic              otp_gnt, otp_rvalid;
  logic [DW-1:0]     otp_rdata;

  int n_chk = 0, n_fail = 0;
  int gnt_dly = 1, rsp_dly = 1;
  int req_cnt = 0;
  logic [OTP_AW-1:0] held_addr;
  logic [OTP_AW-1:0] exp_word;
  bit   chk_word = 1'b0;

  always #4 clk = ~clk;

  otp_rd_ctrl u_otp_rd_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .prov_done_i(prov),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .otp_req_o(otp_req), .otp_addr_o(otp_addr), .otp_gnt_i(otp_gnt),
    .otp_rvalid_i(otp_rvalid), .otp_rdata_i(otp_rdata)
  );

  function automatic logic [DW-1:0] mem_word(input int unsigned w);
    return 32'h5A00_0001 + w * 32'h0003_0201;
  endfunction

  function automatic bit exp_ok(input logic [DW-1:0] off, input bit p);
    int unsigned w;
    if (off[1:0] != 2'b00) return 1'b0;
    if (off >= 32'hE0) return 1'b0;
    w = off >> 2;
    if (p && w >= 16 && w < 48) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(input bit cond, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // array model with variable grant and response delay
  initial begin
    otp_gnt = 1'b0; otp_rvalid = 1'b0; otp_rdata = '0;
    forever begin
      @(negedge clk);
      if (otp_req) begin
        held_addr = otp_addr;
        for (int i = 0; i < gnt_dly; i++) begin
          @(negedge clk);
          check(otp_req && otp_addr == held_addr, "R10", {26'd0, otp_addr}, {26'd0, held_addr});
        end
        otp_gnt = 1'b1;
        req_cnt++;
        if (chk_word) check(otp_addr == exp_word, "R3", {26'd0, otp_addr}, {26'd0, exp_word});
        @(negedge clk);
        otp_gnt = 1'b0;
        for (int i = 0; i < rsp_dly; i++) @(negedge clk);
        otp_rvalid = 1'b1;
        otp_rdata  = mem_word(held_addr);
        @(negedge clk);
        otp_rvalid = 1'b0;
        otp_rdata  = '0;
      end
    end
  end

  task automatic wr(input logic [REG_AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [REG_AW-1:0] a, output logic [DW-1:0] d);
    we = 1'b0; addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_done(output logic [DW-1:0] s);
    for (int i = 0; i < 100; i++) begin
      rd(REG_CTRL, s);
      if (s[STS_DONE]) break;
      @(negedge clk);
    end
  endtask

  task automatic do_read(input logic [DW-1:0] off, input bit p, input string tag);
    logic [DW-1:0] s, d;
    int c0;
    bit ok;
    ok = exp_ok(off, p);
    prov = p;
    c0 = req_cnt;
    exp_word = off[OTP_AW+1:2];
    chk_word = ok;
    wr(REG_OFFS, off);
    wr(REG_CTRL, 32'h1);
    wait_done(s);
    rd(REG_RDATA, d);
    check(s[1:0] == {!ok, 1'b1}, tag, s, {30'd0, !ok, 1'b1});
    check(d == (ok ? mem_word(off >> 2) : 32'd0), tag, d, ok ? mem_word(off >> 2) : 32'd0);
    check(req_cnt == c0 + (ok ? 1 : 0), tag, req_cnt, c0 + (ok ? 1 : 0));
    chk_word = 1'b0;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    logic [DW-1:0] s, d, off;
    int c0;
    bit p;
    void'($urandom(32'h1234_ABCD));
    we = 1'b0; addr = '0; wdata = '0; prov = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    rd(REG_CTRL, s);  check(s == 0, "R9", s, 0);
    rd(REG_OFFS, s);  check(s == 0, "R9", s, 0);
    rd(REG_RDATA, s); check(s == 0, "R9", s, 0);
    check(!otp_req, "R9", otp_req, 0);

    // R1 offset readback and unmapped address
    wr(REG_OFFS, 32'hDEAD_BEEF);
    rd(REG_OFFS, s); check(s == 32'hDEAD_BEEF, "R1", s, 32'hDEAD_BEEF);
    rd(12'h20C, s);  check(s == 0, "R1", s, 0);

    // directed partition corners
    do_read(32'h00, 1'b1, "R3");
    do_read(32'h3C, 1'b1, "R3");
    do_read(32'hC0, 1'b1, "R3");
    do_read(32'hDC, 1'b1, "R3");
    do_read(32'h40, 1'b1, "R4");
    do_read(32'hBC, 1'b1, "R4");
    do_read(32'h80, 1'b1, "R4");
    do_read(32'h40, 1'b0, "R5");
    do_read(32'hBC, 1'b0, "R5");
    do_read(32'h41, 1'b0, "R6");
    do_read(32'h02, 1'b1, "R6");
    do_read(32'hE0, 1'b0, "R7");
    do_read(32'hFFFF_FFFC, 1'b0, "R7");

    // R2 other command bytes ignored
    do_read(32'h10, 1'b1, "R3");
    c0 = req_cnt;
    wr(REG_CTRL, 32'h03);
    wr(REG_CTRL, 32'hFF);
    wr(REG_CTRL, 32'h00);
    repeat (4) @(negedge clk);
    rd(REG_CTRL, s);  check(s == 32'h1, "R2", s, 32'h1);
    rd(REG_RDATA, d); check(d == mem_word(4), "R2", d, mem_word(4));
    check(req_cnt == c0, "R2", req_cnt, c0);

    // R8 overlapping command ignored, DONE cleared on accept
    gnt_dly = 6; rsp_dly = 2;
    prov = 1'b1;
    c0 = req_cnt;
    wr(REG_OFFS, 32'h08);
    wr(REG_CTRL, 32'h1);
    rd(REG_CTRL, s); check(s[STS_DONE] == 1'b0, "R8", s, 0);
    wr(REG_OFFS, 32'hC4);
    wr(REG_CTRL, 32'h1);
    wait_done(s);
    rd(REG_RDATA, d);
    check(s[1:0] == 2'b01, "R8", s, 1);
    check(d == mem_word(2), "R8", d, mem_word(2));
    repeat (12) @(negedge clk);
    check(req_cnt == c0 + 1, "R8", req_cnt, c0 + 1);
    rd(REG_OFFS, s); check(s == 32'hC4, "R1", s, 32'hC4);

    // random mix
    for (int it = 0; it < 80; it++) begin
      gnt_dly = $urandom_range(0, 3);
      rsp_dly = $urandom_range(0, 3);
      p = 1'($urandom_range(0, 1));
      case ($urandom_range(0, 3))
        0: off = 32'($urandom_range(0, 55)) << 2;
        1: off = 32'($urandom_range(0, 255));
        2: off = 32'($urandom_range(16, 47)) << 2;
        default: off = $urandom;
      endcase
      if (!exp_ok(off, p)) begin
        if (off[1:0] != 0) do_read(off, p, "R6");
        else if (off >= 32'hE0) do_read(off, p, "R7");
        else do_read(off, p, "R4");
      end else if (!p && off >= 32'h40 && off < 32'hC0) do_read(off, p, "R5");
      else do_read(off, p, "R3");
    end

    report();
    $finish;
  end

endmodule